// File: doc/BRIEF.md
# Debug Module Abstract Register Bank

This block is the register side of a debug module that a debugger reaches over a simple register bus. Each cycle the bus carries an address, write data, a read strobe and a write strobe. The bank holds:

- a control register with the module-enable bit, a system-reset request and two optional hart-selection bits;
- a status register with a busy flag, a sticky command-error code and the two word counts;
- an array of argument words and an array of program-buffer words;
- an auto-execute mask;
- a write-only command register.

Hart execution is not modelled. A stub that stays busy for a fixed number of cycles stands in for each command run. Every run is announced on a start strobe that carries the command word.

A command is supported when its top byte is zero. Any other command is refused and sets the "not supported" error. Once an auto-execute mask bit is set, each read or write of the matching argument or program-buffer word starts the last supported command again.

Clearing the enable bit wipes the module state. The system-reset request bit is only driven out and touches nothing inside the bank. The bus has no back-pressure: every access completes in the cycle it is presented. Read data comes back one cycle later with a valid strobe.

Top module: `dbg_abs_regbank`

## Requirements
- R1: After reset, the control register reads 0 and the status register reads 0x04000002, for 2 argument words and 4 buffer words. While the enable bit (control bit 0) is 0, writes to argument words have no effect.
- R2: Control bit 0 (enable) and bit 1 (system reset) are read/write, and `sys_reset_o` follows bit 1. Bits 2 and 3 (hart reset, multi-hart select) always read 0.
- R3: Argument words (addresses 0x00 + i) and buffer words (addresses 0x20 + i) hold all 32 bits, both for a pattern and for its inverse. Indices at or above the configured count read 0.
- R4: A COMMAND write (address 0x13) whose bits [31:24] are nonzero starts nothing. It sets the error field (status bits [10:8]) to 2, "not supported". COMMAND reads 0. While the error field is nonzero, no command and no auto-execute run starts.
- R5: Writing 1s to status bits [10:8] clears the matching error bits. Otherwise a nonzero error field keeps its value.
- R6: In the auto-execute register (address 0x12), bits [11:0] enable argument words and bits [31:16] enable buffer words. Only bits below each count can be set; all other bits read 0.
- R7: A COMMAND write with bits [31:24] zero pulses `exec_start` in that cycle with `exec_cmd` equal to the command. Status bit 12 (busy) is then 1 for exactly EXEC_CYCLES cycles.
- R8: Each read or write of an argument or buffer word whose mask bit is set, made while busy is 0 and the error field is 0, pulses `exec_start` once with the last supported command.
- R9: A write to a word, the auto-execute register or COMMAND while busy is 1 is ignored. If the error field was 0, it becomes 1 ("busy").
- R10: Setting and then clearing the system-reset bit leaves the error field, the auto-execute register and all words unchanged.
- R11: Writing 0 to the enable bit resets the error field, the auto-execute register and all words to 0.
- R12: A read returns its data on `bus_rdata`, with `bus_rvalid` high, in the cycle after `bus_rd`. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| bus_rvalid | output | 1 | Read data valid |
| sys_reset_o | output | 1 | System reset request (control bit 1) |
| exec_start | output | 1 | One-cycle pulse when a command run begins |
| exec_cmd | output | 32 | Command word for the run being started |

## Verification
The sharpest collision is a word access that lands in the last busy cycle of a command run, the same cycle in which the execution stub finishes. The bench issues a command, waits exactly two idle cycles and then writes an argument word. It expects the write to be refused and the busy error to be raised. It then repeats the sequence with three idle cycles and expects the write to land. A second collision is a back-to-back read of an auto-execute word: the first read must start a run, and the second, arriving while busy, must start nothing and raise no error. A scoreboard queue matches each read result against the value predicted from the requirements, and a start counter checks how many runs were launched.

// File: rtl/dbgrb_pkg.sv
package dbgrb_pkg;
  localparam int ADDR_W = 7;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 7'h10;
  localparam logic [ADDR_W-1:0] A_STAT = 7'h11;
  localparam logic [ADDR_W-1:0] A_AUTO = 7'h12;
  localparam logic [ADDR_W-1:0] A_CMD  = 7'h13;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_BUSY  = 3'd1;
  localparam logic [2:0] ERR_UNSUP = 3'd2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DATA, SEL_PBUF, SEL_CTRL, SEL_STAT, SEL_AUTO, SEL_CMD
  } sel_e;
endpackage

// File: rtl/dbgrb_decode.sv
module dbgrb_decode
  import dbgrb_pkg::*;
#(
  parameter int DATA_WORDS = 2,
  parameter int PBUF_WORDS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    idx = addr[IDX_W-1:0];
    sel = SEL_NONE;
    if (addr[6:4] == 3'd0 && int'(idx) < DATA_WORDS) sel = SEL_DATA;
    else if (addr[6:4] == 3'd2 && int'(idx) < PBUF_WORDS) sel = SEL_PBUF;
    else if (addr == A_CTRL) sel = SEL_CTRL;
    else if (addr == A_STAT) sel = SEL_STAT;
    else if (addr == A_AUTO) sel = SEL_AUTO;
    else if (addr == A_CMD)  sel = SEL_CMD;
  end
endmodule

// File: rtl/dbgrb_words.sv
module dbgrb_words
  import dbgrb_pkg::*;
#(
  parameter int N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rword
);
  generate
    if (N == 0) begin : g_empty
      assign rword = '0;
    end else begin : g_mem
      localparam int IW = (N > 1) ? $clog2(N) : 1;
      logic [WORD_W-1:0] mem [N];
      for (genvar i = 0; i < N; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                       mem[i] <= '0;
          else if (clr)                     mem[i] <= '0;
          else if (we && int'(idx) == i)    mem[i] <= wdata;
        end
      end
      assign rword = (int'(idx) < N) ? mem[idx[IW-1:0]] : '0;
    end
  endgenerate
endmodule

// File: rtl/dbgrb_exec.sv
module dbgrb_exec #(
  parameter int CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic launch,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr)             cnt_q <= '0;
    else if (launch && !busy) cnt_q <= CW'(CYCLES);
    else if (busy)            cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/dbg_abs_regbank.sv
module dbg_abs_regbank
  import dbgrb_pkg::*;
#(
  parameter int DATA_WORDS  = 2,
  parameter int PBUF_WORDS  = 4,
  parameter int EXEC_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              sys_reset_o,
  output logic              exec_start,
  output logic [WORD_W-1:0] exec_cmd
);
  localparam logic [11:0] DMASK = 12'((1 << DATA_WORDS) - 1);
  localparam logic [15:0] PMASK = 16'((1 << PBUF_WORDS) - 1);

  logic              active_q, ndm_q;
  logic [2:0]        err_q;
  logic [11:0]       auto_dat_q;
  logic [15:0]       auto_pb_q;
  logic [WORD_W-1:0] last_cmd_q, rdata_q, rd_mux, dat_word, pb_word, stat_word;
  logic              rvalid_q, busy;
  sel_e              sel;
  logic [IDX_W-1:0]  idx;

  dbgrb_decode #(.DATA_WORDS(DATA_WORDS), .PBUF_WORDS(PBUF_WORDS)) u_dec (
    .addr(bus_addr), .sel(sel), .idx(idx));

  // Access qualification
  logic guarded_wr, blocked, ok, cmd_ok, cmd_sup, auto_hit, launch;
  logic [15:0] auto_dat_ext;
  assign auto_dat_ext = {4'b0, auto_dat_q};
  assign guarded_wr = bus_wr && (sel == SEL_DATA || sel == SEL_PBUF ||
                                 sel == SEL_AUTO || sel == SEL_CMD);
  assign blocked  = active_q && busy && guarded_wr;
  assign ok       = active_q && !busy && (err_q == ERR_NONE);
  assign cmd_sup  = (bus_wdata[31:24] == 8'h00);
  assign cmd_ok   = bus_wr && (sel == SEL_CMD) && ok;
  assign auto_hit = (bus_rd || bus_wr) && ok &&
                    ((sel == SEL_DATA && auto_dat_ext[idx]) ||
                     (sel == SEL_PBUF && auto_pb_q[idx]));
  assign launch     = (cmd_ok && cmd_sup) || auto_hit;
  assign exec_start = launch;
  assign exec_cmd   = cmd_ok ? bus_wdata : last_cmd_q;

  dbgrb_exec #(.CYCLES(EXEC_CYCLES)) u_exec (
    .clk(clk), .rst_n(rst_n), .clr(!active_q), .launch(launch), .busy(busy));

  logic dat_we, pb_we;
  assign dat_we = bus_wr && sel == SEL_DATA && active_q && !busy;
  assign pb_we  = bus_wr && sel == SEL_PBUF && active_q && !busy;

  dbgrb_words #(.N(DATA_WORDS)) u_data (
    .clk(clk), .rst_n(rst_n), .clr(!active_q), .we(dat_we), .idx(idx),
    .wdata(bus_wdata), .rword(dat_word));

  dbgrb_words #(.N(PBUF_WORDS)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(!active_q), .we(pb_we), .idx(idx),
    .wdata(bus_wdata), .rword(pb_word));

  // Control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ndm_q    <= 1'b0;
    end else if (bus_wr && sel == SEL_CTRL) begin
      active_q <= bus_wdata[0];
      ndm_q    <= bus_wdata[1];
    end
  end
  assign sys_reset_o = ndm_q;

  // Sticky command error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                err_q <= ERR_NONE;
    else if (!active_q)                        err_q <= ERR_NONE;
    else if (err_q == ERR_NONE && blocked)     err_q <= ERR_BUSY;
    else if (cmd_ok && !cmd_sup)               err_q <= ERR_UNSUP;
    else if (bus_wr && sel == SEL_STAT)        err_q <= err_q & ~bus_wdata[10:8];
  end

  // Auto-execute mask and last command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_dat_q <= '0;
      auto_pb_q  <= '0;
      last_cmd_q <= '0;
    end else if (!active_q) begin
      auto_dat_q <= '0;
      auto_pb_q  <= '0;
      last_cmd_q <= '0;
    end else begin
      if (bus_wr && sel == SEL_AUTO && !busy) begin
        auto_dat_q <= bus_wdata[11:0] & DMASK;
        auto_pb_q  <= bus_wdata[31:16] & PMASK;
      end
      if (cmd_ok && cmd_sup) last_cmd_q <= bus_wdata;
    end
  end

  // Read path
  always_comb begin
    stat_word        = '0;
    stat_word[3:0]   = 4'(DATA_WORDS);
    stat_word[10:8]  = err_q;
    stat_word[12]    = busy;
    stat_word[28:24] = 5'(PBUF_WORDS);
    case (sel)
      SEL_DATA: rd_mux = dat_word;
      SEL_PBUF: rd_mux = pb_word;
      SEL_CTRL: rd_mux = {30'b0, ndm_q, active_q};
      SEL_STAT: rd_mux = stat_word;
      SEL_AUTO: rd_mux = {auto_pb_q, 4'b0, auto_dat_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/dbgrb_chk.sv
module dbgrb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        bus_rvalid,
  input logic        exec_start,
  input logic        busy,
  input logic        active,
  input logic [2:0]  err,
  input logic [11:0] auto_dat,
  input logic [15:0] auto_pb
);
  assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> busy);

  assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !exec_start);

  assert_no_start_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 3'd0) |-> !exec_start);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 3'd0 && !bus_wr) |=> $stable(err));

  assert_inactive_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (err == 3'd0 && auto_dat == 12'd0 && auto_pb == 16'd0 && !busy));
endmodule

bind dbg_abs_regbank dbgrb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rvalid(bus_rvalid), .exec_start(exec_start), .busy(busy),
  .active(active_q), .err(err_q), .auto_dat(auto_dat_q), .auto_pb(auto_pb_q));

// File: tb/test_dbg_abs_regbank.sv
module test_dbg_abs_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_rdata, exec_cmd;
  logic        bus_rvalid, sys_reset_o, exec_start;

  int checks = 0, failures = 0, starts = 0;
  logic [31:0] last_started = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  localparam logic [6:0] CTRL = 7'h10, STAT = 7'h11, AUTO = 7'h12, CMD = 7'h13;

  always #4 clk = ~clk;

  dbg_abs_regbank i_dbg_abs_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sys_reset_o(sys_reset_o),
    .exec_start(exec_start), .exec_cmd(exec_cmd));

  function automatic logic [31:0] st(input bit b, input int e);
    return 32'h0400_0002 | (32'(b) << 12) | (32'(e) << 8);
  endfunction

  task automatic check_eq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); @(posedge clk); #1; end
  endtask

  // Monitor: scoreboard for read results and a counter of command starts
  always @(negedge clk) begin
    #1;
    if (exec_start) begin starts++; last_started = exec_cmd; end
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 unexpected read data actual=%08h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_eq(bus_rdata, e, t);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, inactive writes ignored
    rd(CTRL, 32'h0, "R1 ctrl after reset");
    rd(STAT, st(0, 0), "R1 status after reset");
    wr(7'h00, 32'h1234_5678);
    wr(CTRL, 32'h1);
    rd(7'h00, 32'h0, "R1 write while inactive ignored");

    // R2: control bits
    wr(CTRL, 32'hD);
    rd(CTRL, 32'h1, "R2 hart reset and select read 0");
    wr(CTRL, 32'h3);
    check_eq(32'(sys_reset_o), 32'h1, "R2 sys_reset_o high");
    rd(CTRL, 32'h3, "R2 ctrl reads 3");
    wr(CTRL, 32'h1);
    check_eq(32'(sys_reset_o), 32'h0, "R2 sys_reset_o low");

    // R3: words hold pattern and inverse
    for (int inv = 0; inv < 2; inv++) begin
      for (int i = 0; i < 2; i++) wr(7'(i), inv ? ~(32'(i + 1) * 32'h1111_1111) : 32'(i + 1) * 32'h1111_1111);
      for (int i = 0; i < 4; i++) wr(7'h20 + 7'(i), inv ? ~(32'(i + 1) * 32'h1111_1111) : 32'(i + 1) * 32'h1111_1111);
      for (int i = 0; i < 2; i++) rd(7'(i), inv ? ~(32'(i + 1) * 32'h1111_1111) : 32'(i + 1) * 32'h1111_1111, "R3 data word");
      for (int i = 0; i < 4; i++) rd(7'h20 + 7'(i), inv ? ~(32'(i + 1) * 32'h1111_1111) : 32'(i + 1) * 32'h1111_1111, "R3 buffer word");
    end
    wr(7'h02, 32'hFFFF_FFFF);
    rd(7'h02, 32'h0, "R3 data index beyond count");
    wr(7'h24, 32'hFFFF_FFFF);
    rd(7'h24, 32'h0, "R3 buffer index beyond count");
    rd(7'h7F, 32'h0, "R12 unmapped address reads 0");

    // R4 / R5: unsupported commands and error clearing
    s0 = starts;
    wr(CMD, 32'hAAAA_AAAA);
    rd(STAT, st(0, 2), "R4 unsupported sets err 2");
    rd(CMD, 32'h0, "R4 command reads 0");
    wr(STAT, 32'h0000_0700);
    rd(STAT, st(0, 0), "R5 w1c clears err");
    wr(CMD, 32'h5555_5555);
    rd(STAT, st(0, 2), "R4 second unsupported pattern");
    wr(STAT, 32'h0000_0100);
    rd(STAT, st(0, 2), "R5 partial clear keeps err");
    wr(STAT, 32'h0000_0200);
    rd(STAT, st(0, 0), "R5 matching bit clears err");
    check_eq(32'(starts - s0), 32'd0, "R4 unsupported starts nothing");

    // R7: supported command and busy window
    s0 = starts;
    wr(CMD, 32'h0000_1234);
    check_eq(32'(starts - s0), 32'd1, "R7 start pulse");
    check_eq(last_started, 32'h0000_1234, "R7 exec_cmd");
    rd(STAT, st(1, 0), "R7 busy after launch");
    idle(2);
    rd(STAT, st(0, 0), "R7 busy ends after EXEC_CYCLES");

    // R6: auto-exec mask width
    wr(AUTO, 32'hFFFF_FFFF);
    rd(AUTO, 32'h000F_0003, "R6 only bits below counts set");

    // R8: auto-exec relaunch
    s0 = starts;
    rd(7'h00, ~32'h1111_1111, "R8 auto read returns data");
    idle(4);
    wr(7'h22, 32'h0BAD_F00D);
    idle(4);
    rd(7'h01, ~32'h2222_2222, "R8 auto read word 1");
    idle(4);
    check_eq(32'(starts - s0), 32'd3, "R8 one start per access");
    check_eq(last_started, 32'h0000_1234, "R8 relaunches last command");
    wr(AUTO, 32'h0000_0001);
    s0 = starts;
    rd(7'h22, 32'h0BAD_F00D, "R8 unmasked word read");
    idle(4);
    check_eq(32'(starts - s0), 32'd0, "R8 unmasked access starts nothing");
    rd(7'h00, ~32'h1111_1111, "R8 back-to-back read 1");
    rd(7'h00, ~32'h1111_1111, "R8 back-to-back read 2");
    idle(4);
    check_eq(32'(starts - s0), 32'd1, "R8 read while busy no relaunch");
    rd(STAT, st(0, 0), "R8 read while busy no error");

    // R9: write in the last busy cycle
    wr(AUTO, 32'h0);
    wr(CMD, 32'h0000_1234);
    idle(2);
    wr(7'h00, 32'h0000_CAFE);
    idle(2);
    rd(STAT, st(0, 1), "R9 write while busy sets err 1");
    rd(7'h00, ~32'h1111_1111, "R9 blocked write ignored");
    s0 = starts;
    wr(CMD, 32'hAAAA_AAAA);
    rd(STAT, st(0, 1), "R9 busy err not overwritten");
    wr(CMD, 32'h0000_0042);
    check_eq(32'(starts - s0), 32'd0, "R4 no start while err set");
    wr(STAT, 32'h0000_0700);
    wr(CMD, 32'h0000_1234);
    idle(3);
    wr(7'h00, 32'h0000_CAFE);
    rd(7'h00, 32'h0000_CAFE, "R9 write after busy accepted");
    rd(STAT, st(0, 0), "R9 no error after busy");

    // R10: system reset leaves state
    wr(AUTO, 32'h0001_0001);
    wr(CMD, 32'hAAAA_AAAA);
    wr(CTRL, 32'h3);
    wr(CTRL, 32'h1);
    s0 = starts;
    rd(STAT, st(0, 2), "R10 err kept");
    rd(AUTO, 32'h0001_0001, "R10 auto kept");
    rd(7'h00, 32'h0000_CAFE, "R10 data kept");
    rd(7'h20, ~32'h1111_1111, "R10 buffer kept");
    idle(2);
    check_eq(32'(starts - s0), 32'd0, "R4 auto access with err set");

    // R11: enable clear wipes state
    wr(CTRL, 32'h0);
    wr(CTRL, 32'h1);
    rd(STAT, st(0, 0), "R11 err reset");
    rd(AUTO, 32'h0, "R11 auto reset");
    rd(7'h00, 32'h0, "R11 data reset");
    rd(7'h23, 32'h0, "R11 buffer reset");

    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R12 pending reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule